// File: doc/BRIEF.md
# Memory Window Control Register with Local-to-Global Translation

This block holds three memory-map control bits and translates one window of the CPU's 16-bit local address space into a 23-bit global address. The bits are an emulated-memory enable, a high-half-only selector and an on-chip memory enable. Two of them take their reset values from configuration inputs. Each bit follows its own write policy. The emulated-memory enable is fixed after reset. The other two bits may be written once in normal and emulation operation, and any number of times in special operation.

The translator watches local addresses 0x4000 to 0x7FFF. With the high-half selector clear, that window lands on the internal fixed page at global 0x7F_4000 to 0x7F_7FFF. With the selector set, it lands on global 0x14_4000 to 0x14_7FFF and is marked as an external access. When the on-chip memory enable is clear, a CPU or debug access to the internal page is flagged as not mapped. A coprocessor access is never flagged this way.

In emulation operation the register is mirrored on the external bus. Reads return the value presented by the external bus, and writes are also forwarded outward.

Top module: `memwin_ctl`

## Requirements
- R1: After reset, reading byte address 0x0013 outside emulation mode returns bit 2 equal to `cfg_emu_i`, bit 1 equal to 0 and bit 0 equal to `cfg_mem_i`. Bits 7..3 read 0. A read of any other address returns 0x00.
- R2: No write ever changes bit 2 (emulated-memory enable).
- R3: `mode_i` = 2'b00 selects normal mode and 2'b01 selects emulation mode. In either mode, the first write to 0x0013 after reset loads bits 1 and 0 from the write data in the next cycle. Every later write in these modes leaves both bits unchanged until reset. Writes to other addresses change nothing.
- R4: `mode_i` = 2'b10 or 2'b11 selects special mode. In special mode, every write to 0x0013 loads bits 1 and 0 in the next cycle. Special-mode writes do not use up the single write allowed in normal or emulation mode.
- R5: When bit 1 is 0 and `loc_addr_i` lies in 0x4000..0x7FFF, `glb_addr_o` equals 0x7F0000 + `loc_addr_i`, `glb_ext_o` is 0 and `glb_win_o` is 1, all in the same cycle.
- R6: When bit 1 is 1 and `loc_addr_i` lies in the window, `glb_addr_o` equals 0x140000 + `loc_addr_i` and `glb_ext_o` is 1.
- R7: `glb_unmapped_o` is 1 exactly when the address is in the window, bit 1 is 0, bit 0 is 0 and `acc_cpu_i` is 1. A coprocessor access (`acc_cpu_i` = 0) never raises it.
- R8: In emulation mode, a read of 0x0013 returns `ext_rdata_i`, and `ext_wr_o` is 1 in the same cycle as a write to 0x0013. Outside emulation mode, `ext_wr_o` stays 0.
- R9: Outside the window, `glb_addr_o` is `loc_addr_i` zero-extended, and `glb_ext_o`, `glb_unmapped_o` and `glb_win_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_emu_i | input | 1 | Reset value of the emulated-memory enable |
| cfg_mem_i | input | 1 | Reset value of the on-chip memory enable |
| mode_i | input | 2 | Operating mode: 00 normal, 01 emulation, 1x special |
| bus_addr_i | input | 16 | Register bus byte address |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| ext_rdata_i | input | 8 | External bus data returned in emulation mode |
| ext_wr_o | output | 1 | Write forwarded to the external bus |
| acc_cpu_i | input | 1 | 1 for a CPU or debug access, 0 for a coprocessor access |
| loc_addr_i | input | 16 | Local address to translate |
| glb_addr_o | output | 23 | Global address |
| glb_ext_o | output | 1 | Window access targets external space |
| glb_unmapped_o | output | 1 | Window access to internal page while memory is disabled |
| glb_win_o | output | 1 | Local address lies in the translated window |

## Verification
Read data, `ext_wr_o` and all translation outputs are combinational, so their results are due in the same cycle as the stimulus. A write changes the register bits at the next rising edge. The first read or translation that can show the new bits is therefore one cycle after the strobe. The bench drives inputs just after each rising edge. A behavioural model updates at the rising edge, and the bench compares every output with the model at the falling edge. Each check thus sees both the combinational result of the current inputs and the register state left by writes in earlier cycles.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int unsigned WO_BITS = 2;   // index 1: high-half, index 0: memory enable

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_EMUL     = 2'b01,
        MODE_SPECIAL  = 2'b10,
        MODE_SPECIAL2 = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic               emu;
        logic [WO_BITS-1:0] wo_val;
        logic [WO_BITS-1:0] wo_used;
    } ctl_state_t;

    function automatic logic is_special(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/memwin_ctl_reg.sv
module memwin_ctl_reg
    import memwin_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_emu_i,
    input  logic               cfg_mem_i,
    input  logic               wr_sel_i,
    input  logic [1:0]         mode_i,
    input  logic [WO_BITS-1:0] wdata_i,
    output logic               emu_o,
    output logic [WO_BITS-1:0] wo_o
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < WO_BITS; b++) begin
            if (wr_sel_i) begin
                if (is_special(mode_i)) begin
                    st_d.wo_val[b] = wdata_i[b];
                end else if (!st_q.wo_used[b]) begin
                    st_d.wo_val[b]  = wdata_i[b];
                    st_d.wo_used[b] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.emu     <= cfg_emu_i;
            st_q.wo_val  <= {1'b0, cfg_mem_i};
            st_q.wo_used <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign emu_o = st_q.emu;
    assign wo_o  = st_q.wo_val;

    // R2
    emu_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_sel_i |=> $stable(st_q.emu));

    // R4
    special_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_sel_i && is_special(mode_i)) |=> (st_q.wo_val == $past(wdata_i)));

    generate
        for (genvar g = 0; g < WO_BITS; g++) begin : g_lock
            // R3
            lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.wo_used[g] && !(wr_sel_i && is_special(mode_i)))
                    |=> $stable(st_q.wo_val[g]));
        end
    endgenerate

endmodule

// File: rtl/memwin_xlat.sv
module memwin_xlat #(
    parameter int unsigned LADDR_W  = 16,
    parameter int unsigned GADDR_W  = 23,
    parameter logic [GADDR_W-LADDR_W-1:0] INT_PAGE = 7'h7F,
    parameter logic [GADDR_W-LADDR_W-1:0] EXT_PAGE = 7'h14
) (
    input  logic [LADDR_W-1:0] loc_addr_i,
    input  logic               high_half_i,
    input  logic               mem_en_i,
    input  logic               acc_cpu_i,
    output logic [GADDR_W-1:0] glb_addr_o,
    output logic               ext_o,
    output logic               unmapped_o,
    output logic               win_o
);

    localparam int unsigned PAGE_W = GADDR_W - LADDR_W;

    logic in_win;

    assign in_win = (loc_addr_i[LADDR_W-1 -: 2] == 2'b01);

    always_comb begin
        glb_addr_o = {{PAGE_W{1'b0}}, loc_addr_i};
        ext_o      = 1'b0;
        unmapped_o = 1'b0;
        if (in_win) begin
            glb_addr_o = {(high_half_i ? EXT_PAGE : INT_PAGE), loc_addr_i};
            ext_o      = high_half_i;
            unmapped_o = !high_half_i && !mem_en_i && acc_cpu_i;
        end
    end

    assign win_o = in_win;

endmodule

// File: rtl/memwin_ctl.sv
module memwin_ctl
    import memwin_pkg::*;
#(
    parameter int unsigned LADDR_W  = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned GADDR_W  = 23,
    parameter logic [LADDR_W-1:0] REG_ADDR = 16'h0013
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_emu_i,
    input  logic               cfg_mem_i,
    input  logic [1:0]         mode_i,
    input  logic [LADDR_W-1:0] bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [DATA_W-1:0]  ext_rdata_i,
    output logic               ext_wr_o,
    input  logic               acc_cpu_i,
    input  logic [LADDR_W-1:0] loc_addr_i,
    output logic [GADDR_W-1:0] glb_addr_o,
    output logic               glb_ext_o,
    output logic               glb_unmapped_o,
    output logic               glb_win_o
);

    localparam int unsigned PAD_W = DATA_W - 1 - WO_BITS;

    logic               sel;
    logic               emul;
    logic               emu_bit;
    logic [WO_BITS-1:0] wo_bits;

    assign sel  = (bus_addr_i == REG_ADDR);
    assign emul = (mode_i == MODE_EMUL);

    memwin_ctl_reg u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_emu_i (cfg_emu_i),
        .cfg_mem_i (cfg_mem_i),
        .wr_sel_i  (sel && bus_wr_i),
        .mode_i    (mode_i),
        .wdata_i   (bus_wdata_i[WO_BITS-1:0]),
        .emu_o     (emu_bit),
        .wo_o      (wo_bits)
    );

    memwin_xlat #(
        .LADDR_W (LADDR_W),
        .GADDR_W (GADDR_W)
    ) u_xlat (
        .loc_addr_i  (loc_addr_i),
        .high_half_i (wo_bits[1]),
        .mem_en_i    (wo_bits[0]),
        .acc_cpu_i   (acc_cpu_i),
        .glb_addr_o  (glb_addr_o),
        .ext_o       (glb_ext_o),
        .unmapped_o  (glb_unmapped_o),
        .win_o       (glb_win_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (sel) begin
            bus_rdata_o = emul ? ext_rdata_i : {{PAD_W{1'b0}}, emu_bit, wo_bits};
        end
    end

    assign ext_wr_o = sel && bus_wr_i && emul;

    // R6
    ext_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        glb_ext_o |-> (glb_win_o && glb_addr_o[GADDR_W-1:LADDR_W] == 7'h14));

    // R5
    int_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glb_win_o && !glb_ext_o) |-> (glb_addr_o[GADDR_W-1:LADDR_W] == 7'h7F));

    // R7
    unmapped_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        glb_unmapped_o |-> (acc_cpu_i && glb_win_o && !glb_ext_o));

    // R9
    outside_flat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glb_win_o |-> (!glb_ext_o && !glb_unmapped_o
                        && glb_addr_o[GADDR_W-1:LADDR_W] == '0));

    // R8
    ext_wr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_wr_o |-> (mode_i == MODE_EMUL && bus_wr_i));

endmodule

// File: tb/memwin_ctl_tb.sv
`timescale 1ns/1ps
module memwin_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_emu = 1'b0, cfg_mem = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  ext_rdata = 8'hA5;
    logic        ext_wr;
    logic        cpu = 1'b1;
    logic [15:0] loc = 16'h0000;
    logic [22:0] glb;
    logic        g_ext, g_unm, g_win;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    checking = 0;

    always #2.5 clk = ~clk;

    memwin_ctl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_emu_i(cfg_emu), .cfg_mem_i(cfg_mem),
        .mode_i(mode), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_rdata_i(ext_rdata),
        .ext_wr_o(ext_wr), .acc_cpu_i(cpu), .loc_addr_i(loc),
        .glb_addr_o(glb), .glb_ext_o(g_ext), .glb_unmapped_o(g_unm),
        .glb_win_o(g_win)
    );

    // behavioural reference state
    bit m_emu, m_hh, m_me, m_locked;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_emu <= cfg_emu; m_hh <= 0; m_me <= cfg_mem; m_locked <= 0;
        end else if (bus_wr && bus_addr == 16'h0013) begin
            if (mode >= 2) begin
                m_hh <= wdata[1]; m_me <= wdata[0];
            end else if (!m_locked) begin
                m_hh <= wdata[1]; m_me <= wdata[0]; m_locked <= 1;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && checking) begin
            int e_rd, e_g, e_x, e_u, e_w, e_wr;
            e_rd = 0;
            if (bus_addr == 16'h0013)
                e_rd = (mode == 2'b01) ? int'(ext_rdata) : (m_emu * 4 + m_hh * 2 + m_me);
            e_wr = (bus_wr && bus_addr == 16'h0013 && mode == 2'b01) ? 1 : 0;
            if (loc >= 16'h4000 && loc <= 16'h7FFF) begin
                e_g = (m_hh ? 'h140000 : 'h7F0000) + int'(loc);
                e_x = m_hh; e_w = 1;
                e_u = (!m_hh && !m_me && cpu) ? 1 : 0;
            end else begin
                e_g = int'(loc); e_x = 0; e_u = 0; e_w = 0;
            end
            cmp("rdata", int'(rdata), e_rd);
            cmp("ext_wr", int'(ext_wr), e_wr);
            cmp("glb_addr", int'(glb), e_g);
            cmp("glb_ext", int'(g_ext), e_x);
            cmp("unmapped", int'(g_unm), e_u);
            cmp("win", int'(g_win), e_w);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(bit e, bit m);
        checking = 0;
        rst_n = 0; cfg_emu = e; cfg_mem = m; bus_wr = 0;
        tick(2);
        rst_n = 1;
        checking = 1;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; wdata = d; bus_wr = 1;
        tick();
        bus_wr = 0; bus_addr = 16'h0013;
        tick();
    endtask

    task automatic sweep();
        foreach (sweep_pts[i]) begin
            loc = sweep_pts[i];
            tick();
        end
    endtask

    logic [15:0] sweep_pts [6] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h5A5A, 16'h7FFF, 16'h8000};

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick();
        // R1 reset values, two configurations
        cur_req = "R1"; do_reset(1, 0);
        bus_addr = 16'h0013; tick(2);
        bus_addr = 16'h0012; tick();
        bus_addr = 16'h0013;
        // R7 memory disabled: CPU vs coprocessor
        cur_req = "R7"; loc = 16'h5000; cpu = 1; tick(); cpu = 0; tick(); cpu = 1;
        // R3 first normal write takes, later ones ignored; other addresses ignored
        cur_req = "R3"; wr(16'h0012, 8'hFF); wr(16'h0013, 8'hFF); wr(16'h0013, 8'h00);
        // R2 bit 2 unchanged by the 0x00 write
        cur_req = "R2"; tick();
        // R6 high-half set
        cur_req = "R6"; sweep();
        // R4 special writes take every time
        cur_req = "R4"; mode = 2'b10; wr(16'h0013, 8'h00); wr(16'h0013, 8'h02);
        mode = 2'b11; wr(16'h0013, 8'h05);
        // R5 internal page with memory enabled
        cur_req = "R5"; mode = 2'b00; sweep();
        cur_req = "R1"; do_reset(0, 1); bus_addr = 16'h0013; tick();
        // R4 special write does not consume the normal write
        cur_req = "R4"; mode = 2'b10; wr(16'h0013, 8'h03);
        mode = 2'b00; wr(16'h0013, 8'h00); wr(16'h0013, 8'h03);
        cur_req = "R2"; wr(16'h0013, 8'hFC);
        // R9 outside window
        cur_req = "R9"; loc = 16'h0000; tick(); loc = 16'hFFFF; tick(); loc = 16'h3FFF; tick();
        // R8 emulation: read from external bus, write forwarded and locks
        cur_req = "R8"; do_reset(1, 1); mode = 2'b01; ext_rdata = 8'h3C; tick();
        wr(16'h0013, 8'h02); ext_rdata = 8'hC3; tick();
        wr(16'h0013, 8'h01); mode = 2'b00; tick();
        cur_req = "R7"; loc = 16'h4000; cpu = 1; tick();
        cur_req = "R8"; mode = 2'b10; wr(16'h0013, 8'h00); cpu = 0; tick(); cpu = 1; tick();
        checking = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule